// File: doc/BRIEF.md
# SPI Master Transaction Sequencer

This block runs SPI master transfers. It holds a control word and takes bytes from an external first-word-fall-through transmit queue. It drives SCLK, MOSI and up to eight active-low slave-select lines, and it hands each received byte to a receive queue. Software sets the start bit, and the sequencer then sends bytes one after another for as long as the transmit queue holds data. When the queue runs dry it halts and clears the start bit by itself. At that point it either releases or keeps the slave-select lines, depending on a hold bit.

Slave-select line 0 can be turned into an input for a system with several masters. If another master pulls that line low, the block stops the transfer in progress and releases all of its outputs (their output enables go low). It also records a sticky fault that software must clear. A timer-enable bit is stored here, and the block reports it as active only while the SPI enable bit is off. A flow-control bit is stored and read back only.

Control word layout, by bit position:
- bit 0: enable
- bit 1: master
- bit 2: timer enable
- bit 3: flow control
- bit 4: SS0 as input
- bit 5: start
- bit 6: hold select
- bit 7: fault (reads as the sticky flag; writing 1 clears it)
- bits 15:8: slave mask
- bits 23:16: half-period divider

Top module: `spi_xact_seq`

## Requirements
- R1: After reset the control word reads 24'h040000: every flag and mask bit is 0 and the divider is 4. No output enable is driven, all slave-select outputs are high, and timer_run is 0.
- R2: timer_run equals the timer-enable bit (bit 2) while the enable bit (bit 0) is 0, and it is 0 whenever the enable bit is 1.
- R3: A write with the start bit (bit 5) set is ignored if the written enable bit (bit 0) or master bit (bit 1) is 0, or if the fault flag is set. In that case the start bit reads back 0 and no byte is taken from the transmit queue.
- R4: Each byte goes out MSB first in SPI mode 0. SCLK idles low, and each half period lasts max(divider, 2) clocks. MISO is sampled on each rising SCLK edge, MSB first, and the byte formed is offered with a one-cycle rx_push.
- R5: When a byte ends and the transmit queue is not empty, the next byte is popped in that same cycle and shifted out without releasing slave select. tx_pop is never asserted while the queue is empty.
- R6: When a byte ends with the transmit queue empty, or when start is set while the queue is empty, the start bit clears itself and the sequencer halts.
- R7: Selected slave-select lines go low one half period before the first rising SCLK edge. With the hold bit (bit 6) at 0, they return high one half period after the last falling edge. SCLK is never high while slave select is inactive.
- R8: With the hold bit at 1, the selected lines stay low after the sequencer halts. They return high once the hold bit is written to 0.
- R9: Slave-select line n is driven low during a transfer exactly when mask bit n (bit 8+n) is 1, and any number of lines can be low at once.
- R10: With bits 4 and 1 both at 1, the output enable of slave-select line 0 is 0. In slave mode, bit 4 has no effect: a low level on the SS0 input raises no fault.
- R11: In master mode with SS0 as input, a low SS0 input aborts the transfer without pushing a byte. It sets the sticky fault flag (bit 7), clears start, and drops every output enable. The flag stays set after SS0 returns high, until a write with bit 7 set clears it.
- R12: The flow-control bit (bit 3) is stored and read back, and it does not change the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 24 | Control word write data |
| ctl_rdata | output | 24 | Control word read value, including start and fault |
| timer_run | output | 1 | Timer-active indication |
| tx_empty | input | 1 | Transmit queue is empty |
| tx_data | input | 8 | Head of the transmit queue |
| tx_pop | output | 1 | Take the head byte from the transmit queue |
| rx_push | output | 1 | Received byte valid |
| rx_data | output | 8 | Received byte |
| miso_i | input | 1 | Serial data from the slave |
| ss0_n_i | input | 1 | Slave-select line 0 level when it is used as an input |
| sclk_o | output | 1 | Serial clock |
| sclk_oe | output | 1 | Serial clock output enable |
| mosi_o | output | 1 | Serial data to the slave |
| mosi_oe | output | 1 | Serial data output enable |
| ss_n_o | output | 8 | Active-low slave-select outputs |
| ss_n_oe | output | 8 | Per-line slave-select output enables |

## Verification
The assertions assume the transmit queue behaves as first-word-fall-through: tx_data is valid and stable whenever tx_empty is low, and the queue advances only on tx_pop. They also assume the control word is not rewritten with start set while a run is in progress. The bench's queue model advances only on the clock edge that follows a pop. The bench writes the control word only between runs, except for the fault scenario, which deliberately disturbs a transfer through the SS0 input and not through a register write. The bench's slave model changes MISO only after an observed falling SCLK edge, so the data is stable at every rising edge.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  // Control word flag positions (low byte)
  localparam int unsigned CTL_EN    = 0;
  localparam int unsigned CTL_MST   = 1;
  localparam int unsigned CTL_TMR   = 2;
  localparam int unsigned CTL_FLOW  = 3;
  localparam int unsigned CTL_SS0IN = 4;
  localparam int unsigned CTL_START = 5;
  localparam int unsigned CTL_HOLD  = 6;
  localparam int unsigned CTL_FAULT = 7;
  localparam int unsigned CTL_FLAGS = 8;

  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_SHIFT = 1'b1} seq_state_e;

  typedef struct packed {
    logic fault;
    logic hold;
    logic start;
    logic ss0_in;
    logic flow;
    logic timer;
    logic master;
    logic enable;
  } ctl_flags_t;

  // Clocks per SCLK half period: the divider, never below two
  function automatic int unsigned half_clocks(int unsigned div);
    return (div < 2) ? 2 : div;
  endfunction

  // Half periods per frame: two per bit plus one trailing half
  function automatic int unsigned frame_halves(int unsigned bits);
    return 2 * bits + 1;
  endfunction

endpackage

// File: rtl/spi_seq_sync.sv
module spi_seq_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spi_seq_ctlreg.sv
module spi_seq_ctlreg
  import spi_seq_pkg::*;
#(
  parameter int unsigned SS_W    = 8,
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned DIV_RST = 4,
  localparam int unsigned REG_W  = CTL_FLAGS + SS_W + DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  logic             done,
  input  logic             fault_set,
  output logic [REG_W-1:0] rdata,
  output logic             enable,
  output logic             master,
  output logic             timer,
  output logic             ss0_in,
  output logic             start,
  output logic             hold,
  output logic             fault,
  output logic [SS_W-1:0]  ss_mask,
  output logic [DIV_W-1:0] div
);
  ctl_flags_t       flags_q;
  logic [SS_W-1:0]  mask_q;
  logic [DIV_W-1:0] div_q;

  // A start request is honoured only with the written enable and master set
  logic start_req;
  assign start_req = wdata[CTL_START] && wdata[CTL_EN] && wdata[CTL_MST] && !flags_q.fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      mask_q  <= '0;
      div_q   <= DIV_W'(DIV_RST);
    end else begin
      if (done || !(flags_q.enable && flags_q.master)) flags_q.start <= 1'b0;
      if (we) begin
        flags_q.enable <= wdata[CTL_EN];
        flags_q.master <= wdata[CTL_MST];
        flags_q.timer  <= wdata[CTL_TMR];
        flags_q.flow   <= wdata[CTL_FLOW];
        flags_q.ss0_in <= wdata[CTL_SS0IN];
        flags_q.hold   <= wdata[CTL_HOLD];
        mask_q         <= wdata[CTL_FLAGS +: SS_W];
        div_q          <= wdata[CTL_FLAGS + SS_W +: DIV_W];
        if (start_req)        flags_q.start <= 1'b1;
        if (wdata[CTL_FAULT]) flags_q.fault <= 1'b0;
      end
      if (fault_set) begin
        flags_q.fault <= 1'b1;
        flags_q.start <= 1'b0;
      end
    end
  end

  assign rdata   = {div_q, mask_q, flags_q};
  assign enable  = flags_q.enable;
  assign master  = flags_q.master;
  assign timer   = flags_q.timer;
  assign ss0_in  = flags_q.ss0_in;
  assign start   = flags_q.start;
  assign hold    = flags_q.hold;
  assign fault   = flags_q.fault;
  assign ss_mask = mask_q;
  assign div     = div_q;
endmodule

// File: rtl/spi_seq_engine.sv
module spi_seq_engine
  import spi_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8,
  localparam int unsigned NHALF = frame_halves(DATA_W),
  localparam int unsigned PH_W  = $clog2(NHALF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              abort,
  input  logic              hold_sel,
  input  logic [DIV_W-1:0]  half_len,
  input  logic              tx_empty,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_data,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              ss_act,
  output logic              done,
  output logic              ev_rise,
  output logic              ev_fall,
  output logic              ev_load,
  output logic              ev_end
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(NHALF - 1);

  seq_state_e        state_q;
  logic [PH_W-1:0]   ph_q;
  logic [DIV_W-1:0]  cnt_q;
  logic [DATA_W-1:0] txsh_q;
  logic [DATA_W-1:0] rxsh_q;
  logic              ss_q;

  logic half_end, start_ok;

  assign half_end = (state_q == ST_SHIFT) && (cnt_q == half_len - DIV_W'(1));
  assign ev_end   = half_end && (ph_q == LAST_PH);
  assign ev_rise  = half_end && !ph_q[0] && (ph_q != LAST_PH);
  assign ev_fall  = half_end && ph_q[0];
  assign start_ok = (state_q == ST_IDLE) && go && !abort;
  assign ev_load  = !abort && !tx_empty && (start_ok || ev_end);
  assign done     = !abort && tx_empty && (start_ok || ev_end);

  assign tx_pop  = ev_load;
  assign rx_push = ev_end && !abort;
  assign rx_data = rxsh_q;
  assign sclk    = (state_q == ST_SHIFT) && ph_q[0];
  assign mosi    = txsh_q[DATA_W-1];
  assign ss_act  = ss_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      cnt_q   <= '0;
      txsh_q  <= '0;
      rxsh_q  <= '0;
      ss_q    <= 1'b0;
    end else if (abort) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      cnt_q   <= '0;
      ss_q    <= 1'b0;
    end else if (ev_load) begin
      state_q <= ST_SHIFT;
      ph_q    <= '0;
      cnt_q   <= '0;
      txsh_q  <= tx_data;
      ss_q    <= 1'b1;
    end else if (ev_end) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      cnt_q   <= '0;
      ss_q    <= hold_sel;
    end else if (state_q == ST_SHIFT) begin
      if (half_end) begin
        cnt_q <= '0;
        ph_q  <= ph_q + PH_W'(1);
        if (ev_rise) rxsh_q <= {rxsh_q[DATA_W-2:0], miso};
        if (ev_fall) txsh_q <= {txsh_q[DATA_W-2:0], 1'b0};
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
    end else if (!hold_sel) begin
      ss_q <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_xact_seq.sv
module spi_xact_seq
  import spi_seq_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SS_W        = 8,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned DIV_RST     = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned REG_W      = CTL_FLAGS + SS_W + DIV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [REG_W-1:0]  ctl_wdata,
  output logic [REG_W-1:0]  ctl_rdata,
  output logic              timer_run,
  input  logic              tx_empty,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_data,
  input  logic              miso_i,
  input  logic              ss0_n_i,
  output logic              sclk_o,
  output logic              sclk_oe,
  output logic              mosi_o,
  output logic              mosi_oe,
  output logic [SS_W-1:0]   ss_n_o,
  output logic [SS_W-1:0]   ss_n_oe
);
  logic             enable, master, timer, ss0_in, start, hold, fault;
  logic [SS_W-1:0]  ss_mask;
  logic [DIV_W-1:0] div, half_len;
  logic             ss0_sync, ss0_as_input, fault_event, run_ok, drive;
  logic             go, abort, hold_sel, done, ss_act;
  logic             ev_rise, ev_fall, ev_load, ev_end;

  spi_seq_ctlreg #(.SS_W(SS_W), .DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_ctl (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
    .done(done), .fault_set(fault_event), .rdata(ctl_rdata),
    .enable(enable), .master(master), .timer(timer), .ss0_in(ss0_in),
    .start(start), .hold(hold), .fault(fault), .ss_mask(ss_mask), .div(div)
  );

  spi_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ss0_sync (
    .clk(clk), .rst_n(rst_n), .d(ss0_n_i), .q(ss0_sync)
  );

  assign run_ok       = enable && master;
  assign ss0_as_input = master && ss0_in;
  assign fault_event  = enable && ss0_as_input && !ss0_sync;
  assign drive        = run_ok && !fault;
  assign go           = start && drive;
  assign abort        = fault_event || !run_ok;
  assign hold_sel     = hold && run_ok;
  assign half_len     = DIV_W'(half_clocks(32'(div)));
  assign timer_run    = timer && !enable;

  spi_seq_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .go(go), .abort(abort), .hold_sel(hold_sel),
    .half_len(half_len), .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_data(rx_data), .miso(miso_i), .sclk(sclk_o),
    .mosi(mosi_o), .ss_act(ss_act), .done(done), .ev_rise(ev_rise),
    .ev_fall(ev_fall), .ev_load(ev_load), .ev_end(ev_end)
  );

  assign sclk_oe = drive;
  assign mosi_oe = drive;

  generate
    for (genvar i = 0; i < SS_W; i++) begin : g_ss
      if (i == 0) begin : g_line0
        assign ss_n_o[i]  = !(ss_mask[i] && ss_act);
        assign ss_n_oe[i] = drive && !ss0_as_input;
      end else begin : g_line
        assign ss_n_o[i]  = !(ss_mask[i] && ss_act);
        assign ss_n_oe[i] = drive;
      end
    end
  endgenerate
endmodule

// File: rtl/spi_xact_seq_chk.sv
module spi_xact_seq_chk
  import spi_seq_pkg::*;
#(
  parameter int unsigned SS_W  = 8,
  parameter int unsigned REG_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_we,
  input logic [REG_W-1:0] ctl_wdata,
  input logic             enable,
  input logic             master,
  input logic             ss0_in,
  input logic             start,
  input logic             fault,
  input logic             done,
  input logic             timer_run,
  input logic             tx_pop,
  input logic             tx_empty,
  input logic             rx_push,
  input logic             sclk_o,
  input logic             sclk_oe,
  input logic             mosi_oe,
  input logic             ss_act,
  input logic [SS_W-1:0]  ss_n_oe
);
  // R2: timer never runs while the SPI is on
  p_timer_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> !timer_run);

  // R3: start only rises with enable and master set
  p_start_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start) |-> (enable && master));

  // R4: a received byte is offered for one cycle only
  p_push_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !rx_push);

  // R5: no pop from an empty queue
  p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);

  // R6: halting clears the start bit
  p_done_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ctl_we) |=> !start);

  // R7: SCLK high only inside an active selection
  p_sclk_selected_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> ss_act);

  // R10: SS0 enable dropped when used as input in master mode
  p_ss0_input_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (master && ss0_in) |-> !ss_n_oe[0]);

  // R11: all outputs released while faulted
  p_fault_tristate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!sclk_oe && !mosi_oe && (ss_n_oe == '0)));

  // R11: fault is sticky until cleared by a write
  p_fault_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !(ctl_we && ctl_wdata[CTL_FAULT])) |=> fault);
endmodule

bind spi_xact_seq spi_xact_seq_chk #(.SS_W(SS_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .enable(enable), .master(master), .ss0_in(ss0_in), .start(start),
  .fault(fault), .done(done), .timer_run(timer_run), .tx_pop(tx_pop),
  .tx_empty(tx_empty), .rx_push(rx_push), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
  .mosi_oe(mosi_oe), .ss_act(ss_act), .ss_n_oe(ss_n_oe)
);

// File: tb/spi_xact_seq_test.sv
`timescale 1ns/1ps
module spi_xact_seq_test;
  localparam int REG_W = 24;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ctl_we = 1'b0;
  logic [REG_W-1:0] ctl_wdata = '0;
  logic [REG_W-1:0] ctl_rdata;
  logic             timer_run, tx_empty, tx_pop, rx_push, miso_i;
  logic             ss0_n_i = 1'b1;
  logic [7:0]       tx_data, rx_data, ss_n_o, ss_n_oe;
  logic             sclk_o, sclk_oe, mosi_o, mosi_oe;

  always #4 clk = ~clk;  // 125 MHz

  spi_xact_seq uut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .timer_run(timer_run), .tx_empty(tx_empty),
    .tx_data(tx_data), .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data),
    .miso_i(miso_i), .ss0_n_i(ss0_n_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .ss_n_o(ss_n_o), .ss_n_oe(ss_n_oe)
  );

  int checks = 0;
  int fails  = 0;

  // transmit queue model (first word falls through)
  logic [7:0] txq [0:63];
  int wr_i = 0;
  int rd_i = 0;
  assign tx_empty = (rd_i == wr_i);
  assign tx_data  = txq[rd_i[5:0]];
  always @(posedge clk) if (tx_pop) rd_i <= rd_i + 1;

  // receive collector
  logic [7:0] rxq [0:63];
  int rx_n = 0;
  always @(posedge clk) if (rx_push) begin
    rxq[rx_n[5:0]] <= rx_data;
    rx_n <= rx_n + 1;
  end

  // line monitor and slave model
  int cyc = 0, t_rise = 0, t_fall = 0, t_ssfall = 0;
  int lead = -1, trail = -1, hi_bad = 0, rises = 0, ss_falls = 0, ss_rises = 0;
  int exp_half = 2;
  logic first_rise = 1'b0, p_sclk = 1'b0, p_ss = 1'b0, ss_now;
  logic [31:0] mon_mosi = '0;
  logic [31:0] slv_sh = '0;
  assign miso_i = slv_sh[31];

  always @(negedge clk) begin
    cyc++;
    ss_now = (ss_n_o != 8'hFF);
    if (sclk_o && !p_sclk) begin
      rises++;
      mon_mosi = {mon_mosi[30:0], mosi_o};
      if (first_rise) begin lead = cyc - t_ssfall; first_rise = 1'b0; end
      t_rise = cyc;
    end
    if (!sclk_o && p_sclk) begin
      if (cyc - t_rise != exp_half) hi_bad++;
      t_fall = cyc;
      slv_sh = slv_sh << 1;
    end
    if (ss_now && !p_ss) begin ss_falls++; t_ssfall = cyc; first_rise = 1'b1; end
    if (!ss_now && p_ss) begin ss_rises++; trail = cyc - t_fall; end
    p_sclk = sclk_o;
    p_ss   = ss_now;
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // control word: b0 en, b1 master, b2 timer, b3 flow, b4 ss0 input,
  // b5 start, b6 hold, b7 fault clear, [15:8] mask, [23:16] divider
  function automatic logic [23:0] mk(bit en, bit mst, bit tmr, bit flow, bit ss0in,
                                     bit st, bit hold, bit fclr, logic [7:0] mask,
                                     logic [7:0] dv);
    return {dv, mask, fclr, hold, st, ss0in, flow, tmr, mst, en};
  endfunction

  task automatic wr(logic [23:0] w);
    ctl_we = 1'b1; ctl_wdata = w;
    tick();
    ctl_we = 1'b0;
  endtask

  task automatic push(logic [7:0] b);
    txq[wr_i[5:0]] = b;
    wr_i++;
  endtask

  task automatic clear_mon();
    rises = 0; hi_bad = 0; ss_falls = 0; ss_rises = 0; lead = -1; trail = -1;
    mon_mosi = '0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      if (!ctl_rdata[5]) break;
      tick();
    end
  endtask

  task automatic t_reset();  // R1
    chk("R1", "control word", 32'(ctl_rdata), 32'h040000);
    chk("R1", "sclk_oe", 32'(sclk_oe), 0);
    chk("R1", "mosi_oe", 32'(mosi_oe), 0);
    chk("R1", "ss_n_oe", 32'(ss_n_oe), 0);
    chk("R1", "ss_n_o", 32'(ss_n_o), 32'hFF);
    chk("R1", "timer_run", 32'(timer_run), 0);
  endtask

  task automatic t_timer();  // R2
    wr(mk(0, 0, 1, 0, 0, 0, 0, 0, 8'h00, 8'd4));
    chk("R2", "timer_run spi off", 32'(timer_run), 1);
    wr(mk(1, 1, 1, 0, 0, 0, 0, 0, 8'h00, 8'd4));
    chk("R2", "timer_run spi on", 32'(timer_run), 0);
  endtask

  task automatic t_start_ignored();  // R3
    clear_mon();
    push(8'h77);
    wr(mk(0, 1, 0, 0, 0, 1, 0, 0, 8'h01, 8'd2));
    tick(4);
    chk("R3", "start when disabled", 32'(ctl_rdata[5]), 0);
    wr(mk(1, 0, 0, 0, 0, 1, 0, 0, 8'h01, 8'd2));
    tick(4);
    chk("R3", "start in slave mode", 32'(ctl_rdata[5]), 0);
    chk("R3", "queue untouched", 32'(tx_empty), 0);
    chk("R3", "no sclk edges", 32'(rises), 0);
    rd_i = wr_i;
  endtask

  task automatic t_single();  // R4 R6 R7
    int base;
    base = rx_n;
    clear_mon();
    exp_half = 3;
    slv_sh = {8'h3C, 24'h0};
    push(8'hA5);
    wr(mk(1, 1, 0, 0, 0, 1, 0, 0, 8'h01, 8'd3));
    wait_idle();
    tick(3);
    chk("R4", "bytes received", 32'(rx_n - base), 1);
    chk("R4", "rx byte", 32'(rxq[base[5:0]]), 32'h3C);
    chk("R4", "mosi byte", 32'(mon_mosi[7:0]), 32'hA5);
    chk("R4", "rising edges", 32'(rises), 8);
    chk("R4", "bad high halves", 32'(hi_bad), 0);
    chk("R7", "lead clocks", 32'(lead), 3);
    chk("R7", "trail clocks", 32'(trail), 3);
    chk("R7", "ss released", 32'(ss_n_o), 32'hFF);
    chk("R6", "start cleared", 32'(ctl_rdata[5]), 0);
  endtask

  task automatic t_chain();  // R5 R9 R4
    int base;
    base = rx_n;
    clear_mon();
    exp_half = 2;
    slv_sh = {8'hC1, 8'hC2, 8'hC3, 8'h00};
    push(8'h11); push(8'h22); push(8'h33);
    wr(mk(1, 1, 0, 0, 0, 1, 0, 0, 8'h05, 8'd1));
    tick(3);
    chk("R9", "two lines selected", 32'(ss_n_o), 32'hFA);
    wait_idle();
    tick(3);
    chk("R5", "bytes received", 32'(rx_n - base), 3);
    chk("R5", "rx bytes", {8'h0, rxq[base[5:0]], rxq[6'(base + 1)], rxq[6'(base + 2)]},
        32'h00C1C2C3);
    chk("R5", "mosi bytes", {8'h0, mon_mosi[23:0]}, 32'h00112233);
    chk("R5", "single selection", 32'(ss_falls * 16 + ss_rises), 32'h11);
    chk("R5", "queue drained", 32'(tx_empty), 1);
    chk("R4", "divider clamp lead", 32'(lead), 2);
    chk("R4", "divider clamp halves", 32'(hi_bad), 0);
  endtask

  task automatic t_empty_start();  // R6
    clear_mon();
    wr(mk(1, 1, 0, 0, 0, 1, 0, 0, 8'h01, 8'd2));
    tick(3);
    chk("R6", "start cleared on empty", 32'(ctl_rdata[5]), 0);
    chk("R6", "no selection", 32'(ss_falls), 0);
  endtask

  task automatic t_hold();  // R8
    clear_mon();
    slv_sh = '0;
    push(8'h5A);
    wr(mk(1, 1, 0, 0, 0, 1, 1, 0, 8'h02, 8'd2));
    wait_idle();
    tick(4);
    chk("R8", "line held low", 32'(ss_n_o), 32'hFD);
    wr(mk(1, 1, 0, 0, 0, 0, 0, 0, 8'h02, 8'd2));
    tick(2);
    chk("R8", "line released", 32'(ss_n_o), 32'hFF);
  endtask

  task automatic t_ss0();  // R10
    ss0_n_i = 1'b0;
    wr(mk(1, 0, 0, 0, 1, 0, 0, 0, 8'h00, 8'd2));
    tick(5);
    chk("R10", "no fault in slave mode", 32'(ctl_rdata[7]), 0);
    ss0_n_i = 1'b1;
    tick(4);
    wr(mk(1, 1, 0, 0, 1, 0, 0, 0, 8'hFF, 8'd2));
    tick();
    chk("R10", "ss0 enable dropped", 32'(ss_n_oe), 32'hFE);
  endtask

  task automatic t_fault();  // R11
    int base;
    base = rx_n;
    clear_mon();
    push(8'h81); push(8'h42);
    wr(mk(1, 1, 0, 0, 1, 1, 0, 0, 8'h02, 8'd4));
    tick(20);
    ss0_n_i = 1'b0;
    tick(6);
    chk("R11", "fault flag", 32'(ctl_rdata[7]), 1);
    chk("R11", "start cleared", 32'(ctl_rdata[5]), 0);
    chk("R11", "enables dropped", {sclk_oe, mosi_oe, ss_n_oe}, 0);
    chk("R11", "no byte pushed", 32'(rx_n - base), 0);
    rd_i = wr_i;
    ss0_n_i = 1'b1;
    tick(5);
    chk("R11", "fault sticky", 32'(ctl_rdata[7]), 1);
    wr(mk(1, 1, 0, 0, 1, 1, 0, 0, 8'h02, 8'd4));
    tick();
    chk("R11", "start ignored in fault", 32'(ctl_rdata[5]), 0);
    wr(mk(1, 1, 0, 0, 1, 0, 0, 1, 8'h02, 8'd4));
    tick();
    chk("R11", "fault cleared", 32'(ctl_rdata[7]), 0);
  endtask

  task automatic t_flow();  // R12
    wr(mk(1, 1, 0, 1, 0, 0, 0, 0, 8'h00, 8'd2));
    chk("R12", "flags readback", 32'(ctl_rdata[7:0]), 32'h0B);
    chk("R12", "outputs still driven", {sclk_oe, mosi_oe}, 32'h3);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_timer();
    t_start_ignored();
    t_single();
    t_chain();
    t_empty_start();
    t_hold();
    t_ss0();
    t_fault();
    t_flow();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule